// File: doc/BRIEF.md
# Screen-to-Screen Rectangle Copy Engine

This block copies a rectangle of pixels from one place in video memory to another. The source and the destination can each lie in any of four frame buffers, and each buffer is described by its own byte base offset. A context word names the source buffer and holds four destination-enable bits. The block also takes a source point, a destination point, a width and height in pixels, a shared line pitch in bytes and a pixel-depth code. The engine reads the whole source rectangle, one byte per memory transfer, into an internal staging store. Only after that does it write the staged bytes to the destination. Because of this ordering, a copy whose source and destination overlap in the same buffer still gives the right result.

The memory side is a single synchronous byte port with a request/ready handshake. Read data is taken in the same cycle that ready is seen. The control flow is a four-state machine:
- **IDLE**: waits for `start`. The transition IDLE→READ is taken when a start request is accepted.
- **READ**: issues one read per accepted transfer. READ→WRITE is taken on the last source byte.
- **WRITE**: drains the staging store. WRITE→DONE is taken on the last destination byte.
- **DONE**: raises the done pulse for one cycle, then DONE→IDLE.

A start request that is not accepted leaves the machine in IDLE.

Top module: `rect_copy_engine`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are 0, and no memory request is made while `busy` is 0.
- R2: The source buffer index is `ctx[1:0]`. Every read address uses the base offset of that buffer.
- R3: `ctx[5:2]` are destination enables for buffers 0..3 (bit 2+i enables buffer i). The highest-numbered set enable selects the destination. With no enable set, buffer 0 is used.
- R4: Bytes per pixel come from `depth`: code 0 (8 bpp) gives 1, codes 1 and 2 (15/16 bpp) give 2, and code 3 (32 bpp) gives 4. A row spans width × bytes-per-pixel bytes.
- R5: The byte address is base + y·pitch + x·bytes-per-pixel + byte offset. Bytes go in ascending order within a row, and rows go in ascending y, one row at a time. This holds for reads at the source point and for writes at the destination point.
- R6: Every read of a copy is issued before its first write. The bytes written equal the source bytes as they stood before the copy, even when the two rectangles overlap.
- R7: While `mem_req` is 1 and `mem_ready` is 0, the next cycle keeps `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged.
- R8: A `start` given while `busy` is 1 is ignored. It causes no extra memory transfers and no change to `cross_buf`.
- R9: A start request is refused when the width or height is zero, or when the rectangle holds more than STAGE_BYTES bytes (default 64). A refused request causes no busy, no memory request and no done. A rectangle of exactly STAGE_BYTES bytes is accepted.
- R10: `done` is high for exactly one cycle, in the cycle after the last write is accepted. `busy` falls in the following cycle.
- R11: On an accepted start, `cross_buf` is set to 1 if the source and destination base offsets differ and to 0 otherwise. It holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Copy request, sampled in IDLE |
| ctx | input | 6 | [1:0] source buffer, [5:2] destination enables |
| buf_base | input | 48 | Four 12-bit base offsets, buffer i at [12i+11:12i] |
| pitch | input | 12 | Line pitch in bytes |
| depth | input | 2 | Pixel depth code |
| src_x | input | 8 | Source x in pixels |
| src_y | input | 8 | Source y in lines |
| dst_x | input | 8 | Destination x in pixels |
| dst_y | input | 8 | Destination y in lines |
| width | input | 8 | Rectangle width in pixels |
| height | input | 8 | Rectangle height in lines |
| busy | output | 1 | Copy in progress (not IDLE) |
| done | output | 1 | One-cycle completion pulse |
| cross_buf | output | 1 | Source and destination bases differ |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer accepted this cycle |

## Verification
The hardest case to reach is an overlapping copy inside one buffer while the memory stalls at random. Only there does an engine that interleaves reads and writes go wrong, and only there do wrong handshake holds corrupt data. The stimulus sweeps every depth code, every source index and all sixteen destination-enable patterns. The source and destination points are chosen so that the rectangles often overlap, and two buffers share one base so that same-buffer copies also occur with different indices. The ready line comes from a free-running LFSR, so stalls fall on reads, on writes and on the READ→WRITE turn.

// File: rtl/rce_pkg.sv
package rce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } rce_state_e;

    // log2 of bytes per pixel for a depth code
    function automatic logic [1:0] depth_shift(input logic [1:0] code);
        unique case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            2'd2:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/rce_buf_select.sv
module rce_buf_select #(
    parameter int NBUF   = 4,
    parameter int BIDX_W = 2
) (
    input  logic [BIDX_W+NBUF-1:0] ctx,
    output logic [BIDX_W-1:0]      src_idx,
    output logic [BIDX_W-1:0]      dst_idx
);
    always_comb begin
        src_idx = ctx[BIDX_W-1:0];
        dst_idx = '0;
        for (int i = 0; i < NBUF; i++) begin
            if (ctx[BIDX_W+i]) dst_idx = BIDX_W'(i);
        end
    end
endmodule

// File: rtl/rce_addr_gen.sv
module rce_addr_gen #(
    parameter int ADDR_W  = 12,
    parameter int COORD_W = 8,
    parameter int RB_W    = 10
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [ADDR_W-1:0]  pitch,
    input  logic [COORD_W-1:0] x,
    input  logic [ADDR_W-1:0]  y,
    input  logic [1:0]         sh,
    input  logic [RB_W-1:0]    boff,
    output logic [ADDR_W-1:0]  addr
);
    logic [ADDR_W-1:0] line_off;
    logic [ADDR_W-1:0] pix_off;

    assign line_off = y * pitch;
    assign pix_off  = ADDR_W'(x) << sh;
    assign addr     = base + line_off + pix_off + ADDR_W'(boff);
endmodule

// File: rtl/rce_stage_buf.sv
module rce_stage_buf #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    assign rd_data = store[rd_addr];
endmodule

// File: rtl/rect_copy_engine.sv
module rect_copy_engine
    import rce_pkg::*;
#(
    parameter int NBUF        = 4,
    parameter int ADDR_W      = 12,
    parameter int COORD_W     = 8,
    parameter int STAGE_BYTES = 64,
    localparam int BIDX_W     = $clog2(NBUF),
    localparam int CTX_W      = BIDX_W + NBUF
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CTX_W-1:0]       ctx,
    input  logic [NBUF*ADDR_W-1:0] buf_base,
    input  logic [ADDR_W-1:0]      pitch,
    input  logic [1:0]             depth,
    input  logic [COORD_W-1:0]     src_x,
    input  logic [COORD_W-1:0]     src_y,
    input  logic [COORD_W-1:0]     dst_x,
    input  logic [COORD_W-1:0]     dst_y,
    input  logic [COORD_W-1:0]     width,
    input  logic [COORD_W-1:0]     height,
    output logic                   busy,
    output logic                   done,
    output logic                   cross_buf,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic [7:0]             mem_rdata,
    input  logic                   mem_ready
);
    localparam int RB_W  = COORD_W + 2;
    localparam int TOT_W = RB_W + COORD_W;
    localparam int SP_W  = $clog2(STAGE_BYTES);

    rce_state_e state_q, state_d;

    logic [BIDX_W-1:0]  src_idx, dst_idx;
    logic [ADDR_W-1:0]  src_base_in, dst_base_in;
    logic [RB_W-1:0]    rb_in;
    logic [TOT_W-1:0]   total_in;
    logic               fits, accept, xfer, last_byte, last_row, last_all;

    logic [ADDR_W-1:0]  src_base_q, dst_base_q, pitch_q;
    logic [COORD_W-1:0] sx_q, sy_q, dx_q, dy_q, h_q;
    logic [1:0]         sh_q;
    logic [RB_W-1:0]    rb_q, bx_q;
    logic [COORD_W-1:0] ry_q;
    logic [SP_W-1:0]    sp_q;
    logic               cross_q;

    logic [ADDR_W-1:0]  rd_addr, wr_addr;
    logic [7:0]         stage_q;

    rce_buf_select #(.NBUF(NBUF), .BIDX_W(BIDX_W)) u_sel (
        .ctx(ctx), .src_idx(src_idx), .dst_idx(dst_idx)
    );

    assign src_base_in = buf_base[src_idx*ADDR_W +: ADDR_W];
    assign dst_base_in = buf_base[dst_idx*ADDR_W +: ADDR_W];
    assign rb_in       = RB_W'(width) << depth_shift(depth);
    assign total_in    = TOT_W'(rb_in) * TOT_W'(height);
    assign fits        = (width != '0) && (height != '0) &&
                         (total_in <= TOT_W'(STAGE_BYTES));
    assign accept      = start && (state_q == ST_IDLE) && fits;
    assign xfer        = mem_req && mem_ready;
    assign last_byte   = (bx_q == rb_q - RB_W'(1));
    assign last_row    = (ry_q == h_q - COORD_W'(1));
    assign last_all    = last_byte && last_row;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)           state_d = ST_READ;
            ST_READ:  if (xfer && last_all) state_d = ST_WRITE;
            ST_WRITE: if (xfer && last_all) state_d = ST_DONE;
            ST_DONE:                        state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy     = 1'b1;
        done     = 1'b0;
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = rd_addr;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_READ:  mem_req = 1'b1;
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = wr_addr;
            end
            ST_DONE:  done = 1'b1;
        endcase
    end

    assign mem_wdata = stage_q;
    assign cross_buf = cross_q;

    // operand latch and walk counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_base_q <= '0; dst_base_q <= '0; pitch_q <= '0;
            sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0; h_q <= '0;
            sh_q <= '0; rb_q <= '0; bx_q <= '0; ry_q <= '0; sp_q <= '0;
            cross_q <= 1'b0;
        end else if (accept) begin
            src_base_q <= src_base_in;
            dst_base_q <= dst_base_in;
            pitch_q    <= pitch;
            sx_q <= src_x; sy_q <= src_y; dx_q <= dst_x; dy_q <= dst_y;
            h_q  <= height;
            sh_q <= depth_shift(depth);
            rb_q <= rb_in;
            bx_q <= '0; ry_q <= '0; sp_q <= '0;
            cross_q <= (src_base_in != dst_base_in);
        end else if (xfer) begin
            if (last_byte) begin
                bx_q <= '0;
                ry_q <= last_row ? '0 : ry_q + COORD_W'(1);
            end else begin
                bx_q <= bx_q + RB_W'(1);
            end
            sp_q <= last_all ? '0 : sp_q + SP_W'(1);
        end
    end

    rce_addr_gen #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .RB_W(RB_W)) u_src_ag (
        .base(src_base_q), .pitch(pitch_q), .x(sx_q),
        .y(ADDR_W'(sy_q) + ADDR_W'(ry_q)), .sh(sh_q), .boff(bx_q),
        .addr(rd_addr)
    );

    rce_addr_gen #(.ADDR_W(ADDR_W), .COORD_W(COORD_W), .RB_W(RB_W)) u_dst_ag (
        .base(dst_base_q), .pitch(pitch_q), .x(dx_q),
        .y(ADDR_W'(dy_q) + ADDR_W'(ry_q)), .sh(sh_q), .boff(bx_q),
        .addr(wr_addr)
    );

    rce_stage_buf #(.DEPTH(STAGE_BYTES), .AW(SP_W)) u_stage (
        .clk(clk),
        .wr_en(state_q == ST_READ && xfer),
        .wr_addr(sp_q),
        .wr_data(mem_rdata),
        .rd_addr(sp_q),
        .rd_data(stage_q)
    );

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    // R10
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_we && mem_ready));

    // R6
    read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_req && !mem_we);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> $stable(cross_buf));

endmodule

// File: tb/tb_rect_copy_engine.sv
module tb_rect_copy_engine;
    localparam int AW = 12;
    localparam int MSZ = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [5:0] ctx = '0;
    logic [4*AW-1:0] buf_base;
    logic [AW-1:0] pitch = 12'd32;
    logic [1:0] depth = '0;
    logic [7:0] src_x = '0, src_y = '0, dst_x = '0, dst_y = '0;
    logic [7:0] width = 8'd1, height = 8'd1;
    logic busy, done, cross_buf, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata;
    logic mem_ready;

    always #5 clk = ~clk;

    rect_copy_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctx(ctx),
        .buf_base(buf_base), .pitch(pitch), .depth(depth),
        .src_x(src_x), .src_y(src_y), .dst_x(dst_x), .dst_y(dst_y),
        .width(width), .height(height), .busy(busy), .done(done),
        .cross_buf(cross_buf), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // bases: buf0=0x000, buf1=0x400, buf2=0x000, buf3=0x800
    int bases [4] = '{0, 'h400, 0, 'h800};
    assign buf_base = {12'h800, 12'h000, 12'h400, 12'h000};

    // memory model with LFSR-driven stalls
    logic [7:0] mem [MSZ];
    logic [7:0] snap [MSZ];
    logic [7:0] lf = 8'hA5;
    assign mem_ready = lf[0] | lf[2];
    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) begin
        if (mem_req && mem_ready && mem_we) mem[mem_addr] <= mem_wdata;
        #2 lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end

    int checks = 0, fails = 0, cyc = 0;
    int exp_a [256];
    int exp_n = 0, acc_i = 0, acc_err = 0;
    int done_cnt = 0, done_err = 0, hold_err = 0;
    bit busy_seen = 0, prev_w = 0, pend = 0;
    logic [AW-1:0] pend_a;
    logic [7:0] pend_d;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_seen = 1;
            if (pend && (!mem_req || mem_addr != pend_a || mem_wdata != pend_d && mem_we))
                hold_err++;
            pend = mem_req && !mem_ready;
            pend_a = mem_addr;
            pend_d = mem_wdata;
            if (mem_req && mem_ready) begin
                if (acc_i >= exp_n || mem_addr != AW'(exp_a[acc_i]) ||
                    mem_we != (acc_i >= exp_n / 2))
                    acc_err++;
                acc_i++;
            end
            if (done) begin
                done_cnt++;
                if (!prev_w) done_err++;
            end
            prev_w = mem_req && mem_ready && mem_we;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    task automatic run_copy(input logic [5:0] c, input logic [1:0] d,
                            input int sx, input int sy, input int dx, input int dy,
                            input int w, input int h, input bit acc, input bit intrude);
        int sh, rb, s, t, n, mism, bpp;
        bit ok;
        sh = (d == 0) ? 0 : (d == 3) ? 2 : 1;   // R4
        bpp = 1 << sh;
        rb = w * bpp;
        s = c[1:0];                              // R2
        t = 0;                                   // R3
        for (int i = 0; i < 4; i++) if (c[2+i]) t = i;
        n = 0;
        if (acc) begin
            for (int y = 0; y < h; y++)          // R5 reads
                for (int b = 0; b < rb; b++)
                    exp_a[n++] = bases[s] + (sy + y) * 32 + sx * bpp + b;
            for (int y = 0; y < h; y++)          // R5 writes
                for (int b = 0; b < rb; b++)
                    exp_a[n++] = bases[t] + (dy + y) * 32 + dx * bpp + b;
        end
        for (int i = 0; i < MSZ; i++) snap[i] = mem[i];
        exp_n = n; acc_i = 0; acc_err = 0; done_cnt = 0; done_err = 0;
        hold_err = 0; busy_seen = 0;
        @(negedge clk);
        ctx = c; depth = d; src_x = 8'(sx); src_y = 8'(sy);
        dst_x = 8'(dx); dst_y = 8'(dy); width = 8'(w); height = 8'(h);
        start = 1;
        @(negedge clk);
        start = 0;
        if (acc) begin
            n = 0;
            while (!done && n < 3000) begin
                if (intrude && n == 5) begin
                    ctx = 6'b000110; depth = 0; width = 1; height = 1;
                    src_x = 0; dst_x = 7; start = 1;
                end else start = 0;
                @(negedge clk);
                n++;
            end
            start = 0;
            chk(done, "R10 done seen", done, 1);
            repeat (intrude ? 20 : 2) @(negedge clk);
            chk(!busy, "R10 busy falls", busy, 0);
            chk(acc_err == 0 && acc_i == exp_n,
                intrude ? "R8 access sequence" : "R2 R3 R4 R5 access sequence",
                acc_i - acc_err, exp_n);
            mism = 0;
            for (int y = 0; y < h; y++)
                for (int b = 0; b < rb; b++)
                    if (mem[bases[t] + (dy + y) * 32 + dx * bpp + b] !=
                        snap[bases[s] + (sy + y) * 32 + sx * bpp + b]) mism++;
            chk(mism == 0, "R6 copied bytes", mism, 0);
            chk(done_cnt == 1 && done_err == 0, "R10 single done", done_cnt, 1);
            chk(hold_err == 0, "R7 request hold", hold_err, 0);
            ok = (cross_buf == (bases[s] != bases[t]));
            chk(ok, "R11 cross_buf", cross_buf, bases[s] != bases[t]);
        end else begin
            repeat (20) @(negedge clk);
            chk(!busy_seen && acc_i == 0 && done_cnt == 0, "R9 refused",
                acc_i + busy_seen + done_cnt, 0);
        end
    endtask

    initial begin
        int k;
        for (int i = 0; i < MSZ; i++) mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(!busy && !done && !mem_req, "R1 reset state", {busy, done, mem_req}, 0);

        k = 0;
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 4; s++)
                for (int e = 0; e < 16; e++) begin
                    run_copy({4'(e), 2'(s)}, 2'(d), k % 3, k % 2, (k + 1) % 2,
                             (k / 2) % 3, 1 + k % 3, 1 + k % 4, 1, 0);
                    k++;
                end

        // R9 boundary: exactly STAGE_BYTES accepted, overlapping same buffer
        run_copy(6'b000100, 2'd3, 0, 0, 1, 1, 4, 4, 1, 0);
        // R9 refusals
        run_copy(6'b001000, 2'd0, 0, 0, 1, 1, 0, 3, 0, 0);
        run_copy(6'b001000, 2'd0, 0, 0, 1, 1, 3, 0, 0, 0);
        run_copy(6'b001000, 2'd3, 0, 0, 1, 1, 9, 2, 0, 0);
        // R8 start while busy
        run_copy(6'b100001, 2'd3, 1, 2, 0, 1, 3, 4, 1, 1);
        summary();
    end
endmodule